// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Decoder

This block is the control front end of an EDO-style DRAM device model. It samples the active-low row strobe, the two per-byte column strobes, write enable and output enable on a fast system clock. From their order it classifies each memory cycle and issues one-cycle internal commands: row latch, column latch, read, early write, late write, CAS-before-RAS refresh and RAS-only refresh. The row and column addresses and the active byte lanes come with the commands.

It also computes a drive enable for each byte lane's data drivers. EDO page rules apply: read data stays driven after CAS rises. Output enable can park the drivers until the next CAS fall. A falling write enable, or both strobes high, turn the drivers off. An internal refresh row counter supplies the row for CAS-before-RAS refresh and advances once per refresh. The block is meant to sit in front of a small register-file array used for test.

Top module: `edo_strobe_ctrl`

## Requirements
- R1: A RAS fall while both CAS lanes are high gives a one-cycle `row_latch_o` pulse, with `row_o` equal to the address present at that fall.
- R2: A RAS fall while either CAS lane is low gives a one-cycle `cbr_ref_o` pulse. `row_o` then shows the refresh counter and the external address is ignored. The counter then advances by one.
- R3: The refresh counter is 0 after reset and wraps from 4095 back to 0.
- R4: While a row is open, the first CAS lane to fall gives one `col_latch_o` pulse, with `col_o` equal to address bits [9:0]. `lane_o` bit 0 is the low lane and bit 1 is the high lane. A second lane falling before the last one rises adds to `lane_o` and gives no new column latch.
- R5: With WE high at the column latch, the cycle is a read (`rd_o`). With WE low, it is an early write (`early_wr_o`), and its lanes do not drive whatever OE does.
- R6: WE falling after CAS in a read cycle gives `late_wr_o` if OE is high. If OE is low there is no write pulse and the lanes keep driving.
- R7: RAS rising with no CAS fall since RAS fell gives a one-cycle `ras_only_ref_o` pulse.
- R8: After a read, a lane keeps driving after its CAS rises, as long as RAS and OE stay low and WE stays high.
- R9: OE high while a lane's CAS is high stops that lane driving. The lane stays off even after OE returns low, until its CAS falls again.
- R10: A lane stops driving once RAS and both CAS lanes are high. It also stops when WE falls while its CAS is high.
- R11: Only lanes whose own CAS fell in a read drive their data.
- R12: OE high while CAS is low turns the lane off only for as long as OE stays high.
- R13: After reset all command pulses and drive enables are 0. At most one of row latch, refresh, read and write commands is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| casl_ni | input | 1 | Low-lane column strobe, active low |
| cash_ni | input | 1 | High-lane column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ROW_W | Multiplexed row/column address |
| row_latch_o | output | 1 | Row latch pulse |
| col_latch_o | output | 1 | Column latch pulse |
| rd_o | output | 1 | Read command pulse |
| early_wr_o | output | 1 | Early write pulse (data taken at CAS fall) |
| late_wr_o | output | 1 | Late write pulse (data taken at WE fall) |
| cbr_ref_o | output | 1 | CAS-before-RAS refresh pulse |
| ras_only_ref_o | output | 1 | RAS-only refresh pulse |
| row_o | output | ROW_W | Latched row or refresh row |
| col_o | output | COL_W | Latched column |
| lane_o | output | 2 | Lanes in the current access |
| dq_oe_o | output | 2 | Per-lane data drive enable |

## Verification
The bench uses the default parameters: a 12-bit row, a 10-bit column and a two-stage synchroniser. With these, a full lap of 4096 CAS-before-RAS refreshes fits in the cycle budget, so the counter wrap is seen at the ports. The two-stage delay also keeps each strobe edge three clocks from its command, which bounds how long the bench settles after each pin change. Random row, column, lane and read/write mixes run alongside directed cases: staggered lanes, OE parking, a late write blocked by OE, and the WE-driven turn-off.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_REF  = 2'd2
  } cyc_st_e;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned NUM_CTRL  = 5; // ras, cas lanes, we, oe
endpackage

// File: rtl/edo_sync.sv
module edo_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain[s] <= '0;
        else         chain[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain[s] <= '0;
        else         chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned COL_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ras_i,
  input  logic [NUM_LANES-1:0] cas_i,
  input  logic                 we_i,
  input  logic                 oe_i,
  input  logic [ROW_W-1:0]     addr_i,
  output logic                 in_row_o,
  output logic                 row_latch_o,
  output logic                 col_latch_o,
  output logic                 rd_o,
  output logic                 early_wr_o,
  output logic                 late_wr_o,
  output logic                 cbr_ref_o,
  output logic                 ras_only_ref_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic [NUM_LANES-1:0] lane_o
);
  cyc_st_e          st_q;
  logic             ras_q, cas_any_q, we_q;
  logic             cas_seen_q, acc_rd_q;
  logic [ROW_W-1:0] ref_cnt_q;

  logic cas_any, ras_fall, ras_rise, cas_fall, we_fall;
  assign cas_any  = |cas_i;
  assign ras_fall = ras_i & ~ras_q;
  assign ras_rise = ~ras_i & ras_q;
  assign cas_fall = cas_any & ~cas_any_q;
  assign we_fall  = we_i & ~we_q;   // active-high copy: pin went low
  assign in_row_o = (st_q == ST_ROW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      {ras_q, cas_any_q, we_q, cas_seen_q, acc_rd_q} <= '0;
      ref_cnt_q <= '0;
      {row_latch_o, col_latch_o, rd_o, early_wr_o, late_wr_o} <= '0;
      {cbr_ref_o, ras_only_ref_o} <= '0;
      row_o  <= '0;
      col_o  <= '0;
      lane_o <= '0;
    end else begin
      ras_q     <= ras_i;
      cas_any_q <= cas_any;
      we_q      <= we_i;
      {row_latch_o, col_latch_o, rd_o, early_wr_o, late_wr_o} <= '0;
      {cbr_ref_o, ras_only_ref_o} <= '0;
      if (ras_fall) begin
        if (cas_any) begin
          cbr_ref_o <= 1'b1;
          row_o     <= ref_cnt_q;
          ref_cnt_q <= ref_cnt_q + 1'b1;
          st_q      <= ST_REF;
        end else begin
          row_latch_o <= 1'b1;
          row_o       <= addr_i;
          cas_seen_q  <= 1'b0;
          acc_rd_q    <= 1'b0;
          lane_o      <= '0;
          st_q        <= ST_ROW;
        end
      end else if (ras_rise) begin
        if (st_q == ST_ROW && !cas_seen_q) ras_only_ref_o <= 1'b1;
        st_q <= ST_IDLE;
      end else if (st_q == ST_ROW) begin
        if (cas_fall) begin
          col_latch_o <= 1'b1;
          col_o       <= addr_i[COL_W-1:0];
          lane_o      <= cas_i;
          cas_seen_q  <= 1'b1;
          if (we_i) begin
            early_wr_o <= 1'b1;
            acc_rd_q   <= 1'b0;
          end else begin
            rd_o     <= 1'b1;
            acc_rd_q <= 1'b1;
          end
        end else if (cas_any) begin
          lane_o <= lane_o | cas_i;
          // late write only when OE already parked the drivers
          if (we_fall && acc_rd_q && !oe_i) begin
            late_wr_o <= 1'b1;
            acc_rd_q  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/edo_lane_oe.sv
module edo_lane_oe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_i,
  input  logic cas_i,
  input  logic cas_any_i,
  input  logic we_i,
  input  logic oe_i,
  input  logic in_row_i,
  input  logic late_wr_i,
  output logic drv_o
);
  logic cas_q, we_q, valid_q, park_q;
  logic cas_fall;
  assign cas_fall = cas_i & ~cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {cas_q, we_q, valid_q, park_q} <= '0;
    end else begin
      cas_q <= cas_i;
      we_q  <= we_i;
      if (cas_fall && in_row_i)              valid_q <= ~we_i;
      else if (late_wr_i && cas_i)           valid_q <= 1'b0;
      else if (!ras_i && !cas_any_i)         valid_q <= 1'b0;
      else if (we_i && !we_q && !cas_i)      valid_q <= 1'b0;
      // OE high during this lane's CAS-high time parks it until CAS falls
      if (cas_fall)                          park_q <= 1'b0;
      else if (!cas_i && !oe_i)              park_q <= 1'b1;
    end
  end

  assign drv_o = valid_q & ~park_q & oe_i;
endmodule

// File: rtl/edo_strobe_ctrl.sv
module edo_strobe_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W       = 12,
  parameter int unsigned COL_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ras_ni,
  input  logic                 casl_ni,
  input  logic                 cash_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  input  logic [ROW_W-1:0]     addr_i,
  output logic                 row_latch_o,
  output logic                 col_latch_o,
  output logic                 rd_o,
  output logic                 early_wr_o,
  output logic                 late_wr_o,
  output logic                 cbr_ref_o,
  output logic                 ras_only_ref_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic [NUM_LANES-1:0] lane_o,
  output logic [NUM_LANES-1:0] dq_oe_o
);
  localparam int unsigned SYNC_W = NUM_CTRL + ROW_W;

  logic [SYNC_W-1:0]    sync_d, sync_q;
  logic                 ras_s, we_s, oe_s, in_row;
  logic [NUM_LANES-1:0] cas_s;
  logic [ROW_W-1:0]     addr_s;

  // invert to active-high so reset value means inactive; address rides along
  assign sync_d = {addr_i, ~oe_ni, ~we_ni, ~cash_ni, ~casl_ni, ~ras_ni};
  assign {addr_s, oe_s, we_s, cas_s, ras_s} = sync_q;

  edo_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(sync_d), .q_o(sync_q)
  );

  edo_cycle_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk_i, .rst_ni,
    .ras_i(ras_s), .cas_i(cas_s), .we_i(we_s), .oe_i(oe_s), .addr_i(addr_s),
    .in_row_o(in_row),
    .row_latch_o, .col_latch_o, .rd_o, .early_wr_o, .late_wr_o,
    .cbr_ref_o, .ras_only_ref_o, .row_o, .col_o, .lane_o
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    edo_lane_oe u_lane (
      .clk_i, .rst_ni,
      .ras_i(ras_s), .cas_i(cas_s[l]), .cas_any_i(|cas_s),
      .we_i(we_s), .oe_i(oe_s), .in_row_i(in_row), .late_wr_i(late_wr_o),
      .drv_o(dq_oe_o[l])
    );
  end
endmodule

// File: rtl/edo_strobe_ctrl_chk.sv
module edo_strobe_ctrl_chk #(
  parameter int unsigned ROW_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_ni,
  input logic             casl_ni,
  input logic             cash_ni,
  input logic             row_latch_o,
  input logic             col_latch_o,
  input logic             rd_o,
  input logic             early_wr_o,
  input logic             late_wr_o,
  input logic             cbr_ref_o,
  input logic             ras_only_ref_o,
  input logic [ROW_W-1:0] row_o,
  input logic [1:0]       lane_o,
  input logic [1:0]       dq_oe_o
);
  logic [2:0]       idle_cnt;
  logic             cbr_seen;
  logic [ROW_W-1:0] cbr_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt <= '0;
      cbr_seen <= 1'b0;
      cbr_last <= '0;
    end else begin
      if (!(ras_ni && casl_ni && cash_ni)) idle_cnt <= '0;
      else if (idle_cnt != 3'd7)           idle_cnt <= idle_cnt + 1'b1;
      if (cbr_ref_o) begin
        cbr_seen <= 1'b1;
        cbr_last <= row_o;
      end
    end
  end

  a_r13_one_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({row_latch_o, cbr_ref_o, ras_only_ref_o, rd_o, early_wr_o, late_wr_o}));

  a_r4_col_has_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_latch_o |-> ((rd_o || early_wr_o) && lane_o != 2'b00));

  a_r5_early_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_wr_o |-> ((dq_oe_o & lane_o) == 2'b00));

  a_r2_cbr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cbr_ref_o && cbr_seen) |-> (row_o == ROW_W'(cbr_last + 1'b1)));

  a_r10_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cnt >= 3'd4) |-> (dq_oe_o == 2'b00));

  a_r13_row_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_latch_o |=> !row_latch_o);
endmodule

bind edo_strobe_ctrl edo_strobe_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_ni), .casl_ni(casl_ni),
  .cash_ni(cash_ni), .row_latch_o(row_latch_o), .col_latch_o(col_latch_o),
  .rd_o(rd_o), .early_wr_o(early_wr_o), .late_wr_o(late_wr_o),
  .cbr_ref_o(cbr_ref_o), .ras_only_ref_o(ras_only_ref_o), .row_o(row_o),
  .lane_o(lane_o), .dq_oe_o(dq_oe_o)
);

// File: tb/edo_strobe_ctrl_tb.sv
module edo_strobe_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 12;
  localparam int COL_W = 10;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [ROW_W-1:0] addr = '0;

  logic row_latch, col_latch, rd, early_wr, late_wr, cbr_ref, ras_only;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [1:0] lane, dq_oe;

  int n_row = 0, n_col = 0, n_rd = 0, n_ew = 0, n_lw = 0, n_cbr = 0, n_ro = 0;
  int checks = 0, fails = 0;
  int exp_ref = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_strobe_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .casl_ni(casl_n),
    .cash_ni(cash_n), .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr),
    .row_latch_o(row_latch), .col_latch_o(col_latch), .rd_o(rd),
    .early_wr_o(early_wr), .late_wr_o(late_wr), .cbr_ref_o(cbr_ref),
    .ras_only_ref_o(ras_only), .row_o(row), .col_o(col), .lane_o(lane),
    .dq_oe_o(dq_oe)
  );

  always @(negedge clk) if (rst_n) begin
    n_row <= n_row + int'(row_latch);
    n_col <= n_col + int'(col_latch);
    n_rd  <= n_rd  + int'(rd);
    n_ew  <= n_ew  + int'(early_wr);
    n_lw  <= n_lw  + int'(late_wr);
    n_cbr <= n_cbr + int'(cbr_ref);
    n_ro  <= n_ro  + int'(ras_only);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_drive(input bit is_read, input logic [1:0] lanes);
    return is_read ? int'(lanes) : 0;
  endfunction

  task automatic close_all();
    ras_n = 1'b1; step(1);
    casl_n = 1'b1; cash_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; step(SETTLE);
  endtask

  task automatic open_row(input logic [ROW_W-1:0] r);
    addr = r; ras_n = 1'b0; step(SETTLE);
  endtask

  task automatic do_cbr(input logic [ROW_W-1:0] junk);
    int c0;
    c0 = n_cbr;
    addr = junk;
    casl_n = 1'b0; step(2);
    ras_n = 1'b0; step(5);
    chk(n_cbr == c0 + 1, "R2 cbr pulse", n_cbr - c0, 1);
    chk(int'(row) == exp_ref, "R2/R3 refresh row", int'(row), exp_ref);
    exp_ref = (exp_ref + 1) % (1 << ROW_W);
    ras_n = 1'b1; step(2);
    casl_n = 1'b1; step(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0, s1, s2;
    void'($urandom(32'h5eed_0001));
    step(3);
    // R13 reset state
    chk({row_latch, col_latch, rd, early_wr, late_wr, cbr_ref, ras_only} == 7'b0,
        "R13 reset pulses", 0, 0);
    chk(dq_oe == 2'b00, "R13 reset drive", int'(dq_oe), 0);
    rst_n = 1'b1; step(SETTLE);

    // R1 row latch then read, R4, R5
    s0 = n_row;
    open_row(12'hA5C);
    chk(n_row == s0 + 1, "R1 row pulse", n_row - s0, 1);
    chk(row == 12'hA5C, "R1 row addr", int'(row), 'hA5C);
    s0 = n_rd; s1 = n_col;
    addr = 12'h37F; casl_n = 1'b0; cash_n = 1'b0; step(SETTLE);
    chk(n_rd == s0 + 1 && n_col == s1 + 1, "R5 read pulse", n_rd - s0, 1);
    chk(col == 10'h37F, "R4 column", int'(col), 'h37F);
    chk(lane == 2'b11, "R4 lanes", int'(lane), 3);
    chk(dq_oe == 2'b11, "R5 read drive", int'(dq_oe), 3);
    // R8 EDO hold after CAS rise
    casl_n = 1'b1; cash_n = 1'b1; step(SETTLE);
    chk(dq_oe == 2'b11, "R8 edo hold", int'(dq_oe), 3);
    // R9 OE park during CAS high
    oe_n = 1'b1; step(SETTLE);
    chk(dq_oe == 2'b00, "R9 oe off", int'(dq_oe), 0);
    oe_n = 1'b0; step(SETTLE);
    chk(dq_oe == 2'b00, "R9 stays parked", int'(dq_oe), 0);
    // page read, then R12 OE toggle during CAS low
    s0 = n_rd;
    addr = 12'h012; casl_n = 1'b0; cash_n = 1'b0; step(SETTLE);
    chk(n_rd == s0 + 1 && dq_oe == 2'b11, "R9 unpark on cas fall", int'(dq_oe), 3);
    oe_n = 1'b1; step(SETTLE);
    chk(dq_oe == 2'b00, "R12 oe high cas low", int'(dq_oe), 0);
    oe_n = 1'b0; step(SETTLE);
    chk(dq_oe == 2'b11, "R12 oe back low", int'(dq_oe), 3);
    // R6 late write blocked by OE low
    s0 = n_lw;
    we_n = 1'b0; step(SETTLE);
    chk(n_lw == s0, "R6 blocked late write", n_lw - s0, 0);
    chk(dq_oe == 2'b11, "R6 keeps driving", int'(dq_oe), 3);
    we_n = 1'b1; step(2);
    // R10 WE fall during CAS high
    casl_n = 1'b1; cash_n = 1'b1; step(SETTLE);
    chk(dq_oe == 2'b11, "R8 edo hold 2", int'(dq_oe), 3);
    we_n = 1'b0; step(SETTLE);
    chk(dq_oe == 2'b00, "R10 we disables", int'(dq_oe), 0);
    s0 = n_ro;
    close_all();
    chk(n_ro == s0, "R7 no ras-only after access", n_ro - s0, 0);

    // R10 both strobes high; RAS rise with CAS low keeps data
    open_row(12'h100);
    addr = 12'h055; casl_n = 1'b0; step(SETTLE);
    ras_n = 1'b1; step(SETTLE);
    chk(dq_oe == 2'b01, "R10 ras high cas low holds", int'(dq_oe), 1);
    casl_n = 1'b1; step(SETTLE);
    chk(dq_oe == 2'b00, "R10 both high off", int'(dq_oe), 0);
    close_all();

    // R5 early write with OE low
    s0 = n_ew;
    open_row(12'h222);
    we_n = 1'b0; step(2);
    addr = 12'h3AA; casl_n = 1'b0; cash_n = 1'b0; step(SETTLE);
    chk(n_ew == s0 + 1, "R5 early write pulse", n_ew - s0, 1);
    chk(dq_oe == 2'b00, "R5 early write silent", int'(dq_oe), 0);
    close_all();

    // R6 late write with OE high
    s0 = n_lw;
    open_row(12'h333);
    addr = 12'h101; cash_n = 1'b0; step(SETTLE);
    oe_n = 1'b1; step(SETTLE);
    we_n = 1'b0; step(SETTLE);
    chk(n_lw == s0 + 1, "R6 late write pulse", n_lw - s0, 1);
    close_all();

    // R11 byte lane and R4 staggered lanes
    open_row(12'h444);
    s1 = n_col;
    addr = 12'h0F0; casl_n = 1'b0; step(SETTLE);
    chk(dq_oe == 2'b01 && lane == 2'b01, "R11 low lane only", int'(dq_oe), 1);
    addr = 12'h2FF; cash_n = 1'b0; step(SETTLE);
    chk(n_col == s1 + 1, "R4 single col latch", n_col - s1, 1);
    chk(lane == 2'b11 && col == 10'h0F0, "R4 lane merge", int'(lane), 3);
    chk(dq_oe == 2'b11, "R11 high lane joins", int'(dq_oe), 3);
    close_all();

    // R7 RAS-only refresh
    s0 = n_ro;
    open_row(12'h777);
    ras_n = 1'b1; step(SETTLE);
    chk(n_ro == s0 + 1, "R7 ras-only pulse", n_ro - s0, 1);
    close_all();

    // random accesses
    for (int it = 0; it < 150; it++) begin
      logic [ROW_W-1:0] r;
      logic [COL_W-1:0] c;
      logic [1:0] ln;
      bit is_rd;
      r = ROW_W'($urandom);
      c = COL_W'($urandom);
      ln = 2'($urandom_range(1, 3));
      is_rd = 1'($urandom);
      s0 = n_rd; s1 = n_ew; s2 = n_row;
      open_row(r);
      chk(n_row == s2 + 1 && row == r, "R1 random row", int'(row), int'(r));
      we_n = is_rd; step(2);
      addr = ROW_W'(c);
      casl_n = ~ln[0]; cash_n = ~ln[1]; step(SETTLE);
      chk(col == c && lane == ln, "R4 random column", int'(col), int'(c));
      chk((is_rd ? n_rd - s0 : n_ew - s1) == 1, "R5 random kind", n_rd - s0, int'(is_rd));
      chk(int'(dq_oe) == exp_drive(is_rd, ln), "R11 random drive", int'(dq_oe),
          exp_drive(is_rd, ln));
      close_all();
    end

    // R2/R3 refresh lap with counter wrap
    begin
      int left;
      left = (1 << ROW_W) + 2;
      for (int k = 0; k < left; k++) do_cbr(ROW_W'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule